// File: doc/BRIEF.md
# Threshold-Flagged Packet Stream Source

This block is a packet FIFO that plays the passive side of a streaming link. A local producer pushes words into it one per cycle, each tagged with start-of-packet and end-of-packet flags. A reading master on the far side polls an availability flag, pulls words by raising a read enable, and receives each word one cycle later, qualified by a valid bit.

Availability rises when the number of stored words reaches a fixed threshold, or earlier when a packet end is already waiting. This lets a short or final packet be drained without waiting for the threshold. Once the reader has started, it may keep reading after availability falls, and it stops when valid drops. When the reader pauses, the presented word and its flags hold. A write into a full FIFO is dropped and recorded in a sticky overflow flag.

Top module: `pkt_stream_source`

## Requirements
- R1: After reset, `avail`, `out_val` and `ovf` are 0, and `out_data`, `out_sop` and `out_eop` are 0.
- R2: In the cycle after any clock edge, `avail` is 1 exactly when the stored word count (words written and not yet read) is at least THRESH, or when at least one stored word carries end-of-packet.
- R3: When `rd_ena` is 1 at an edge and at least one word is stored, the oldest stored word appears on `out_data`/`out_sop`/`out_eop` with `out_val` = 1 in the next cycle. Words leave in write order.
- R4: When `rd_ena` is 0 at an edge, `out_val`, `out_data`, `out_sop` and `out_eop` keep their values.
- R5: When `rd_ena` is 1 at an edge and no word is stored, `out_val` is 0 in the next cycle.
- R6: Reads keep returning valid words after `avail` has fallen below the threshold, until the store is empty.
- R7: A write while the count equals DEPTH is discarded, even if a read happens in the same cycle, and `ovf` becomes 1 and stays 1 until reset.
- R8: A write and a read in the same cycle, with the store neither empty nor full, are both performed and leave the count unchanged.
- R9: The sop and eop flags written with a word are presented with that same word. In the written word, sop is bit W+1, eop is bit W, and data is bits W-1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Producer write strobe |
| wr_data | input | W | Word to store |
| wr_sop | input | 1 | Start-of-packet flag of the written word |
| wr_eop | input | 1 | End-of-packet flag of the written word |
| rd_ena | input | 1 | Reader's request for the next word |
| avail | output | 1 | Threshold reached or a packet end is stored |
| out_val | output | 1 | Presented word is valid |
| out_data | output | W | Presented data word |
| out_sop | output | 1 | Start-of-packet of the presented word |
| out_eop | output | 1 | End-of-packet of the presented word |
| ovf | output | 1 | Sticky flag for a discarded write |

## Verification
Random traffic runs in three phases. The write-heavy phase keeps the store near full, which separates correct discard-on-full behaviour from pointer wraparound errors. The read-heavy phase keeps it near empty, which exposes a wrong valid response to reads of an empty store and threshold edges met while falling. The balanced phase exercises simultaneous write and read at every fill level. Directed sequences isolate a lone end-of-packet word below the threshold, draining past the threshold, pause-and-hold, a same-cycle write and read at exactly the threshold, and writes into a full store.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int PSS_WORD_W_DEF = 16;
  localparam int PSS_DEPTH_DEF  = 16;
  localparam int PSS_THRESH_DEF = 4;

  // packed word layout: {sop, eop, data}
  localparam int PSS_FLAG_BITS  = 2;
endpackage

// File: rtl/pss_ram.sv
module pss_ram #(
  parameter int RW    = 18,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register only advances on a pop, so it holds during pauses
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pss_level.sv
module pss_level #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 4,
  parameter int AW     = 4,
  parameter int CW     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_eop,
  input  logic          rd_ena,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] fill,
  output logic          avail,
  output logic          ovf
);
  logic [DEPTH-1:0] eop_map;
  logic [CW-1:0]    eop_cnt;
  logic [CW-1:0]    fill_nx;
  logic [CW-1:0]    eop_nx;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    push    = wr_en  && (fill != CW'(DEPTH));
    pop     = rd_ena && (fill != '0);
    fill_nx = fill + CW'(push) - CW'(pop);
    eop_nx  = eop_cnt + CW'(push && wr_eop) - CW'(pop && eop_map[rd_ptr]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill    <= '0;
      eop_cnt <= '0;
      eop_map <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      avail   <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      fill    <= fill_nx;
      eop_cnt <= eop_nx;
      avail   <= (fill_nx >= CW'(THRESH)) || (eop_nx != '0);
      if (push) begin
        eop_map[wr_ptr] <= wr_eop;
        wr_ptr          <= adv(wr_ptr);
      end
      if (pop) rd_ptr <= adv(rd_ptr);
      if (wr_en && !push) ovf <= 1'b1;
    end
  end

  // R7
  full_write_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && fill == CW'(DEPTH)) |=> ovf);
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  // R8
  both_ops_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_ena && fill != '0 && fill != CW'(DEPTH)) |=> $stable(fill));
  // R2
  thresh_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (fill >= CW'(THRESH)) |-> avail);
  // R2
  eop_avail_chk: assert property (@(posedge clk) disable iff (rst)
    (eop_cnt != '0) |-> avail);
endmodule

// File: rtl/pkt_stream_source.sv
module pkt_stream_source #(
  parameter int W      = pss_pkg::PSS_WORD_W_DEF,
  parameter int DEPTH  = pss_pkg::PSS_DEPTH_DEF,
  parameter int THRESH = pss_pkg::PSS_THRESH_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         wr_sop,
  input  logic         wr_eop,
  input  logic         rd_ena,
  output logic         avail,
  output logic         out_val,
  output logic [W-1:0] out_data,
  output logic         out_sop,
  output logic         out_eop,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = W + pss_pkg::PSS_FLAG_BITS;

  logic          push, pop;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic [RW-1:0] rd_word;

  pss_level #(.DEPTH(DEPTH), .THRESH(THRESH), .AW(AW), .CW(CW)) u_level (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eop(wr_eop), .rd_ena(rd_ena),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill(fill), .avail(avail), .ovf(ovf)
  );

  pss_ram #(.RW(RW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .rst(rst), .we(push), .waddr(wr_ptr),
    .wdata({wr_sop, wr_eop, wr_data}), .re(pop), .raddr(rd_ptr),
    .rdata(rd_word)
  );

  assign {out_sop, out_eop, out_data} = rd_word;

  always_ff @(posedge clk) begin
    if (rst)         out_val <= 1'b0;
    else if (rd_ena) out_val <= pop;
  end

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ena && fill != '0) |=> out_val);
  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ena && fill == '0) |=> !out_val);
  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_ena |=> ($stable(out_val) && $stable(out_data) &&
                 $stable(out_sop) && $stable(out_eop)));
endmodule

// File: tb/sim_pkt_stream_source.sv
module sim_pkt_stream_source;
  localparam int W = 16, DEPTH = 16, THRESH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_ena = 0;
  logic [W-1:0] wr_data = '0;
  logic avail, out_val, out_sop, out_eop, ovf;
  logic [W-1:0] out_data;

  pkt_stream_source #(.W(W), .DEPTH(DEPTH), .THRESH(THRESH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .rd_ena(rd_ena), .avail(avail), .out_val(out_val),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .ovf(ovf)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [W+1:0] q[$];
  logic [W+1:0] exp_word = '0;
  logic exp_val = 0, exp_ovf = 0, exp_avail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic model_avail();
    logic any_eop = 1'b0;
    foreach (q[i]) if (q[i][W]) any_eop = 1'b1;
    return (q.size() >= THRESH) || any_eop;
  endfunction

  task automatic step(input logic we, input logic s, input logic e,
                      input logic [W-1:0] d, input logic re);
    logic full, popped;
    string tag;
    wr_en = we; wr_sop = s; wr_eop = e; wr_data = d; rd_ena = re;
    @(posedge clk);
    full   = (q.size() == DEPTH);
    popped = 1'b0;
    if (re) begin
      if (q.size() > 0) begin
        exp_word = q.pop_front();
        exp_val  = 1'b1;
        popped   = 1'b1;
      end else exp_val = 1'b0;
    end
    if (we) begin
      if (!full) q.push_back({s, e, d});
      else exp_ovf = 1'b1;
    end
    exp_avail = model_avail();
    #1;
    tag = !re ? "R4" : (popped ? "R3" : "R5");
    chk(tag, 32'(out_val), 32'(exp_val));
    chk(tag, 32'(out_data), 32'(exp_word[W-1:0]));
    chk("R9", 32'({out_sop, out_eop}), 32'(exp_word[W+1:W]));
    chk("R2", 32'(avail), 32'(exp_avail));
    chk("R7", 32'(ovf), 32'(exp_ovf));
  endtask

  task automatic idle(); step(0, 0, 0, '0, 0); endtask
  task automatic put(input logic [W-1:0] d, input logic s, input logic e); step(1, s, e, d, 0); endtask
  task automatic get(); step(0, 0, 0, '0, 1); endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk("R1", 32'(avail), 0);
    chk("R1", 32'(out_val), 0);
    chk("R1", 32'(ovf), 0);
    chk("R1", 32'({out_sop, out_eop, out_data}), 0);

    // R2: threshold crossing
    for (int i = 0; i < 3; i++) put(W'(16'h100 + i), i == 0, 0);
    chk("R2", 32'(avail), 0);
    put(16'h103, 0, 0);
    chk("R2", 32'(avail), 1);
    // R6: drain below threshold
    get();
    chk("R6", 32'(avail), 0);
    for (int i = 0; i < 3; i++) begin
      get();
      chk("R6", 32'(out_val), 1);
    end
    get();
    chk("R5", 32'(out_val), 0);
    idle();

    // R2/R9: lone end-of-packet word
    put(16'hBEEF, 1, 1);
    chk("R2", 32'(avail), 1);
    get();
    chk("R9", 32'({out_sop, out_eop}), 32'b11);
    chk("R2", 32'(avail), 0);

    // R4: pause and hold
    put(16'h0A0A, 1, 0); put(16'h0B0B, 0, 1);
    get();
    repeat (3) idle();
    get(); get();

    // R8: simultaneous write and read at threshold
    for (int i = 0; i < THRESH; i++) put(W'(16'h200 + i), 0, 0);
    step(1, 0, 0, 16'h2FF, 1);
    chk("R8", 32'(avail), 1);
    chk("R8", 32'(out_val), 1);
    repeat (THRESH + 1) get();

    // random phases: write-heavy, read-heavy, balanced
    for (int ph = 0; ph < 3; ph++) begin
      int unsigned wp, rp;
      wp = (ph == 0) ? 70 : (ph == 1) ? 30 : 50;
      rp = (ph == 0) ? 30 : (ph == 1) ? 70 : 50;
      for (int i = 0; i < 1500; i++)
        step(($urandom % 100) < wp, ($urandom % 8) == 0, ($urandom % 8) == 0,
             W'($urandom), ($urandom % 100) < rp);
    end
    repeat (DEPTH + 1) get();

    // R7: fill completely, then overfill
    for (int i = 0; i < DEPTH; i++) put(W'(16'h300 + i), 0, 0);
    put(16'hDEAD, 0, 1);
    chk("R7", 32'(ovf), 1);
    chk("R7", 32'(avail), 1);
    step(1, 0, 1, 16'hFACE, 1);
    repeat (DEPTH) get();
    chk("R7", 32'(out_data), 32'(16'h300 + DEPTH - 1));
    chk("R7", 32'(avail), 0);
    chk("R7", 32'(ovf), 1);

    summary();
    $finish;
  end
endmodule